// File: doc/BRIEF.md
# Edge, Level and Pin-Change Interrupt Sensing

This block turns pin activity into interrupt requests. A small set of dedicated request pins (two by default) each has a 2-bit sense selector and an enable. A sensing pin can request on a low level, on any change, on a falling edge or on a rising edge. A wider bank of general pins (28 by default) is watched for toggles only. These pins are split into fixed groups of eight, and the last group holds the remainder. Each general pin has its own mask bit, and each group has one enable and one request flag.

Every pin first passes through a synchronizer. Edges are then found by comparing the newest synchronized sample with the one before it. An edge or toggle request is latched and stays set until it is cleared. Two inputs can clear it: a write-one-to-clear strobe from software, or an acknowledge strobe from the interrupt controller that serviced it. A low-level request is not latched; it simply follows the pin. Vectoring and the processor sit outside this block. The block only presents registered request lines.

Top module: `pin_irq_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every request output is 0. Synchronizer and history state reset to 0, so pins must be held low during reset.
- R2: With sense code 2'b00 (low level) and the enable set, the request is 1 exactly while the synchronized pin is 0. It is not latched, and a clear strobe has no effect on it.
- R3: With sense code 2'b01, both a rising and a falling transition set the request.
- R4: With sense code 2'b10, only a falling transition sets the request; a rising one leaves it at 0.
- R5: With sense code 2'b11, only a rising transition sets the request; a falling one leaves it at 0.
- R6: A dedicated pin whose enable bit is 0 never sets its request, whatever the sense code.
- R7: A latched request stays 1 until a 1 is applied on its bit of the write-one-to-clear input or of the acknowledge input. After that clear cycle it reads 0.
- R8: If a new event and a clear land in the same cycle, the event wins and the request stays 1.
- R9: A toggle in either direction on a general pin with its mask bit set raises its group request, provided the group enable is set.
- R10: A general pin with a mask bit of 0, or in a group whose enable is 0, never raises a group request.
- R11: General pin n belongs to group n/8: pins 0–7 drive bit 0, 8–15 bit 1, 16–23 bit 2 and 24–27 bit 3 of the group request output.
- R12: A pin change applied before rising edge k shows on the request output after rising edge k+2. That is two synchronizer stages plus one output register, and the same latency holds for all modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NUM_EXT | Dedicated request pins, asynchronous |
| ext_sense | input | 2*NUM_EXT | Sense code per dedicated pin, bits [2i+1:2i] for pin i |
| ext_en | input | NUM_EXT | Enable per dedicated pin |
| w1c_ext | input | NUM_EXT | Write-one-to-clear strobe per dedicated request |
| ack_ext | input | NUM_EXT | Acknowledge strobe per dedicated request |
| pc_pin | input | NUM_PC | General pins watched for toggles, asynchronous |
| pc_mask | input | NUM_PC | Mask bit per general pin |
| grp_en | input | NUM_GRP | Enable per pin group |
| w1c_grp | input | NUM_GRP | Write-one-to-clear strobe per group request |
| ack_grp | input | NUM_GRP | Acknowledge strobe per group request |
| ext_req | output | NUM_EXT | Registered request per dedicated pin |
| grp_req | output | NUM_GRP | Registered request per pin group |

## Verification
Every result appears on the third rising edge after the pin is driven. A clear or enable input takes effect on the very next edge. The bench drives all inputs just after a falling edge. A behavioural model, fed the same inputs at each rising edge, then uses pin values from two and three edges earlier. Outputs are compared with that model at every falling edge. Directed checks use the same counts: three falling edges after a pin change, or one after a clear pulse. One check sits deliberately at two edges to pin the latency down exactly.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Sense selector for a dedicated request pin.
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  function automatic int grp_count(input int pins, input int per_grp);
    return (pins + per_grp - 1) / per_grp;
  endfunction

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/ext_sense_unit.sv
module ext_sense_unit
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  input  logic       rise,
  input  logic       fall,
  input  logic [1:0] sense,
  input  logic       en,
  input  logic       clr,
  output logic       req
);

  sense_e mode;
  logic   hit;

  assign mode = sense_e'(sense);

  always_comb begin
    case (mode)
      SNS_ANY:  hit = rise | fall;
      SNS_FALL: hit = fall;
      SNS_RISE: hit = rise;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
    end else if (mode == SNS_LOW) begin
      req <= en & ~level;
    end else begin
      req <= (req & ~clr) | (en & hit);
    end
  end

endmodule

// File: rtl/pc_group_unit.sv
module pc_group_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg,
  input  logic [W-1:0] mask,
  input  logic         en,
  input  logic         clr,
  output logic         req
);

  logic hit;

  assign hit = |(chg & mask);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= (req & ~clr) | (en & hit);
  end

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter  int NUM_EXT     = 2,
  parameter  int NUM_PC      = 28,
  parameter  int GRP_W       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_GRP     = grp_count(NUM_PC, GRP_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EXT-1:0]   ext_pin,
  input  logic [2*NUM_EXT-1:0] ext_sense,
  input  logic [NUM_EXT-1:0]   ext_en,
  input  logic [NUM_EXT-1:0]   w1c_ext,
  input  logic [NUM_EXT-1:0]   ack_ext,
  input  logic [NUM_PC-1:0]    pc_pin,
  input  logic [NUM_PC-1:0]    pc_mask,
  input  logic [NUM_GRP-1:0]   grp_en,
  input  logic [NUM_GRP-1:0]   w1c_grp,
  input  logic [NUM_GRP-1:0]   ack_grp,
  output logic [NUM_EXT-1:0]   ext_req,
  output logic [NUM_GRP-1:0]   grp_req
);

  logic [NUM_EXT-1:0] ext_lvl, ext_rise, ext_fall;
  logic [NUM_PC-1:0]  pc_lvl, pc_rise, pc_fall, pc_chg;

  pin_edge_det #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_det (
    .clk(clk), .rst(rst), .din(ext_pin),
    .level(ext_lvl), .rise(ext_rise), .fall(ext_fall)
  );

  pin_edge_det #(.W(NUM_PC), .STAGES(SYNC_STAGES)) u_pc_det (
    .clk(clk), .rst(rst), .din(pc_pin),
    .level(pc_lvl), .rise(pc_rise), .fall(pc_fall)
  );

  assign pc_chg = pc_rise | pc_fall;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    ext_sense_unit u_sense (
      .clk(clk), .rst(rst),
      .level(ext_lvl[i]), .rise(ext_rise[i]), .fall(ext_fall[i]),
      .sense(ext_sense[2*i +: 2]), .en(ext_en[i]),
      .clr(w1c_ext[i] | ack_ext[i]),
      .req(ext_req[i])
    );
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = g * GRP_W;
    localparam int HI = (LO + GRP_W > NUM_PC) ? NUM_PC - 1 : LO + GRP_W - 1;
    localparam int GW = HI - LO + 1;
    pc_group_unit #(.W(GW)) u_grp (
      .clk(clk), .rst(rst),
      .chg(pc_chg[HI:LO]), .mask(pc_mask[HI:LO]),
      .en(grp_en[g]), .clr(w1c_grp[g] | ack_grp[g]),
      .req(grp_req[g])
    );
  end

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NUM_EXT = 2,
  parameter int NUM_GRP = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2*NUM_EXT-1:0] ext_sense,
  input logic [NUM_EXT-1:0]   ext_en,
  input logic [NUM_EXT-1:0]   w1c_ext,
  input logic [NUM_EXT-1:0]   ack_ext,
  input logic [NUM_GRP-1:0]   grp_en,
  input logic [NUM_GRP-1:0]   w1c_grp,
  input logic [NUM_GRP-1:0]   ack_grp,
  input logic [NUM_EXT-1:0]   ext_req,
  input logic [NUM_GRP-1:0]   grp_req
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (ext_req == '0 && grp_req == '0));

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    p_enable_gate_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ext_req[i]) |-> $past(ext_en[i]));

    p_level_unlatched_r2: assert property (@(posedge clk) disable iff (rst)
      (ext_sense[2*i +: 2] == 2'b00 && !ext_en[i]) |=> !ext_req[i]);

    p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ext_req[i] && ext_sense[2*i +: 2] != 2'b00 && !w1c_ext[i] && !ack_ext[i])
      |=> ext_req[i]);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    p_grp_enable_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(grp_req[g]) |-> $past(grp_en[g]));

    p_grp_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (grp_req[g] && !w1c_grp[g] && !ack_grp[g]) |=> grp_req[g]);
  end

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_EXT(NUM_EXT), .NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst(rst), .ext_sense(ext_sense), .ext_en(ext_en),
  .w1c_ext(w1c_ext), .ack_ext(ack_ext), .grp_en(grp_en),
  .w1c_grp(w1c_grp), .ack_grp(ack_grp), .ext_req(ext_req), .grp_req(grp_req)
);

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;

  localparam int NE = 2;
  localparam int NP = 28;
  localparam int GW = 8;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0]   ext_pin   = '0;
  logic [2*NE-1:0] ext_sense = '0;
  logic [NE-1:0]   ext_en    = '0;
  logic [NE-1:0]   w1c_ext   = '0;
  logic [NE-1:0]   ack_ext   = '0;
  logic [NP-1:0]   pc_pin    = '0;
  logic [NP-1:0]   pc_mask   = '0;
  logic [NG-1:0]   grp_en    = '0;
  logic [NG-1:0]   w1c_grp   = '0;
  logic [NG-1:0]   ack_grp   = '0;
  logic [NE-1:0]   ext_req;
  logic [NG-1:0]   grp_req;

  always #5 clk = ~clk;

  pin_irq_ctrl dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_sense(ext_sense),
    .ext_en(ext_en), .w1c_ext(w1c_ext), .ack_ext(ack_ext),
    .pc_pin(pc_pin), .pc_mask(pc_mask), .grp_en(grp_en),
    .w1c_grp(w1c_grp), .ack_grp(ack_grp),
    .ext_req(ext_req), .grp_req(grp_req)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    ended = 0;
  string cur_tag = "R1 reset";

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin history sampled at each rising edge.
  logic [NE-1:0] xh0 = '0, xh1 = '0, xh2 = '0;
  logic [NP-1:0] ph0 = '0, ph1 = '0, ph2 = '0;
  logic [NE-1:0] m_ext = '0;
  logic [NG-1:0] m_grp = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ext = '0;
      m_grp = '0;
      xh0 = '0; xh1 = '0; xh2 = '0;
      ph0 = '0; ph1 = '0; ph2 = '0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        bit s, p, clr, hit;
        s = xh1[i]; p = xh2[i];
        clr = w1c_ext[i] | ack_ext[i];
        case (ext_sense[2*i +: 2])
          2'b00: hit = 0;
          2'b01: hit = (s != p);
          2'b10: hit = (p && !s);
          default: hit = (s && !p);
        endcase
        if (ext_sense[2*i +: 2] == 2'b00) m_ext[i] = ext_en[i] && !s;
        else m_ext[i] = (m_ext[i] && !clr) || (ext_en[i] && hit);
      end
      for (int g = 0; g < NG; g++) begin
        bit any;
        any = 0;
        for (int j = 0; j < NP; j++)
          if (j / GW == g && ph1[j] != ph2[j] && pc_mask[j]) any = 1;
        m_grp[g] = (m_grp[g] && !(w1c_grp[g] || ack_grp[g])) || (grp_en[g] && any);
      end
      xh2 = xh1; xh1 = xh0; xh0 = ext_pin;
      ph2 = ph1; ph1 = ph0; ph0 = pc_pin;
    end
  end

  always @(negedge clk) begin
    if (!ended) begin
      chk(32'(ext_req), 32'(m_ext), {cur_tag, " model ext"});
      chk(32'(grp_req), 32'(m_grp), {cur_tag, " model grp"});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_ext(input logic [NE-1:0] v, input bit use_ack);
    if (use_ack) ack_ext = v; else w1c_ext = v;
    tick(1);
    ack_ext = '0; w1c_ext = '0;
  endtask

  task automatic clr_grp(input logic [NG-1:0] v, input bit use_ack);
    if (use_ack) ack_grp = v; else w1c_grp = v;
    tick(1);
    ack_grp = '0; w1c_grp = '0;
  endtask

  task automatic pc_toggle_chk(input int pin, input logic [NG-1:0] exp, input string tag);
    cur_tag = tag;
    pc_pin[pin] = ~pc_pin[pin];
    tick(3);
    chk(32'(grp_req), 32'(exp), tag);
    clr_grp('1, 1'b1);
  endtask

  logic [31:0] lfsr = 32'h1ACE_5EED;

  initial begin
    tick(5);
    chk(32'(ext_req), 0, "R1 ext during reset");
    rst = 1'b0;
    tick(1);
    chk(32'(grp_req), 0, "R1 grp after reset");

    // R5 rising only
    cur_tag = "R5 rising";
    ext_sense = 4'b0011; ext_en = 2'b01;
    ext_pin[0] = 1'b1; tick(3);
    chk(32'(ext_req[0]), 1, "R5 rise sets");
    ext_pin[0] = 1'b0; tick(3);
    chk(32'(ext_req[0]), 1, "R7 held after falling");
    cur_tag = "R7 clear";
    clr_ext(2'b01, 1'b0);
    chk(32'(ext_req[0]), 0, "R7 w1c clears");

    // R4 falling only
    cur_tag = "R4 falling";
    ext_sense = 4'b0010;
    ext_pin[0] = 1'b1; tick(3);
    chk(32'(ext_req[0]), 0, "R4 rise ignored");
    ext_pin[0] = 1'b0; tick(3);
    chk(32'(ext_req[0]), 1, "R4 fall sets");
    clr_ext(2'b01, 1'b1);
    chk(32'(ext_req[0]), 0, "R7 ack clears");

    // R3 any change
    cur_tag = "R3 any";
    ext_sense = 4'b0001;
    ext_pin[0] = 1'b1; tick(3);
    chk(32'(ext_req[0]), 1, "R3 rise sets");
    clr_ext(2'b01, 1'b0);
    ext_pin[0] = 1'b0; tick(3);
    chk(32'(ext_req[0]), 1, "R3 fall sets");
    clr_ext(2'b01, 1'b0);

    // R2 low level on pin 1
    cur_tag = "R2 level";
    ext_sense = 4'b0001; ext_en = 2'b11;
    tick(1);
    chk(32'(ext_req[1]), 1, "R2 low level requests");
    clr_ext(2'b10, 1'b0);
    chk(32'(ext_req[1]), 1, "R2 clear has no effect");
    ext_pin[1] = 1'b1; tick(2);
    chk(32'(ext_req[1]), 1, "R12 not yet after two edges");
    tick(1);
    chk(32'(ext_req[1]), 0, "R2 drops when high");
    ext_pin[1] = 1'b0; tick(3);
    chk(32'(ext_req[1]), 1, "R2 reasserts when low");
    ext_en[1] = 1'b0; ext_pin[1] = 1'b1; tick(3);

    // R6 enable gate
    cur_tag = "R6 enable";
    ext_sense[1:0] = 2'b11; ext_en[0] = 1'b0;
    ext_pin[0] = 1'b1; tick(3);
    chk(32'(ext_req[0]), 0, "R6 disabled stays low");
    ext_pin[0] = 1'b0; tick(3);

    // R8 event wins over same-cycle clear
    cur_tag = "R8 set vs clear";
    ext_en[0] = 1'b1;
    ext_pin[0] = 1'b1; tick(2);
    w1c_ext = 2'b01; tick(1); w1c_ext = '0;
    chk(32'(ext_req[0]), 1, "R8 event wins");
    clr_ext(2'b01, 1'b0);
    chk(32'(ext_req[0]), 0, "R7 cleared after R8");

    // Pin-change groups
    grp_en = 4'b1111; pc_mask = '0;
    pc_toggle_chk(3, 4'b0000, "R10 mask blocks");
    pc_mask[3] = 1'b1;
    pc_toggle_chk(3, 4'b0001, "R9 toggle down sets");
    pc_toggle_chk(3, 4'b0001, "R9 toggle up sets");
    pc_mask = '1;
    pc_toggle_chk(7,  4'b0001, "R11 pin 7 group 0");
    pc_toggle_chk(8,  4'b0010, "R11 pin 8 group 1");
    pc_toggle_chk(16, 4'b0100, "R11 pin 16 group 2");
    pc_toggle_chk(23, 4'b0100, "R11 pin 23 group 2");
    pc_toggle_chk(24, 4'b1000, "R11 pin 24 group 3");
    pc_toggle_chk(27, 4'b1000, "R11 pin 27 group 3");
    cur_tag = "R7 grp hold";
    pc_pin[12] = ~pc_pin[12]; tick(6);
    chk(32'(grp_req), 4'b0010, "R7 group flag held");
    clr_grp(4'b0010, 1'b0);
    chk(32'(grp_req), 0, "R7 group w1c clears");
    grp_en = 4'b0111;
    pc_toggle_chk(25, 4'b0000, "R10 group enable blocks");

    // Mixed traffic against the model
    cur_tag = "R12 mixed";
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ext_pin = lfsr[1:0];
      if (lfsr[9:8] == 2'b00) pc_pin = pc_pin ^ (NP'(1) << (lfsr[20:16] % NP));
      if (c % 32 == 0) begin
        ext_sense = lfsr[13:10];
        ext_en    = lfsr[15:14];
        pc_mask   = {lfsr[27:0]} | 28'h0F0_F0F0;
        grp_en    = lfsr[31:28];
      end
      w1c_ext = lfsr[3:2] & lfsr[5:4] & lfsr[7:6];
      ack_grp = lfsr[25:22] & lfsr[29:26];
      tick(1);
    end
    w1c_ext = '0; ack_grp = '0;
    tick(4);

    ended = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule